// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading translation entries from memory. It first fetches a root entry from a context table, which is selected by a context number. It then follows pointer entries through up to three levels of page tables. The walk stops at the first final page entry it meets. That entry can map 16 MB, 256 KB or 4 KB, depending on the level where it is found. The block carries no translation cache and does not check permissions. Those jobs belong to neighbouring blocks, which consume the page entry this walker returns.

A request is accepted through a valid/ready pair. It carries the virtual address and the access kind: write, instruction fetch, physical mode and boot mode. The block handles one request at a time. Each walk issues 32-bit word reads, and sometimes one write, on a memory port that holds each request until it is acknowledged and that can signal an error. The answer is a one-cycle response. On success it carries the physical address, a size code and the final entry. On failure it carries a fault type and the level of the failing read.

A walk that succeeds may update the entry it ended on. If the referenced flag is clear, or the access is a write and the modified flag is clear, the walker sets the needed flags. It then stores the updated word back to the address it read it from, before it responds.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to byte address (context table pointer << 4) + (context number << 2).
- R2: Bits [1:0] of a fetched entry give its type: 0 invalid, 1 pointer, 2 final page entry, 3 reserved. A pointer's child table starts at byte address (entry with bits [1:0] cleared) << 4.
- R3: The index into the level 1 table is VA[31:24]. The level 2 index is VA[23:18] and the level 3 index is VA[17:12]. Each index is multiplied by 4 and added to the table base.
- R4: A final entry gives physical address (entry[31:8] << 12) + page offset. The offset is VA[23:0] at level 1 (size code 2, 16 MB), VA[17:0] at level 2 (size code 1, 256 KB) and VA[11:0] at level 3 (size code 0, 4 KB).
- R5: An invalid entry at any level ends the walk with fault type 1. The reported level is the level of that read: 0 for the context table, then 1, 2 or 3.
- R6: A reserved entry ends the walk with fault type 4 and its level. So does a final entry in the context table (level 0), and so does a pointer read at level 3.
- R7: A memory error on a table read ends the walk with fault type 4 and the level of that read.
- R8: When a walk ends on a final entry and bit 5 (referenced) is clear, the walker sets bit 5. When the access is a write and bit 6 (modified) is clear, it sets bit 6. It writes the result to the address the entry came from before responding, and the response carries the updated entry.
- R9: A final entry that already has every flag the access needs causes no memory write, and it is returned unchanged.
- R10: In physical mode no memory access occurs, and the result is a 4 KB, fault-free response. The physical address is the zero-extended VA. The exception is an instruction fetch with boot mode set, which yields the boot ROM base ORed with VA[18:0].
- R11: Only one walk is in flight. req_ready is low from the cycle after acceptance until the response cycle ends, and rsp_valid lasts exactly one cycle.
- R12: A memory request keeps its address, write flag and data unchanged until acknowledged. A write-back goes to the address of the read just before it.
- R13: After reset, req_ready is high, and rsp_valid and mem_req are low. A reset during a walk abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_phys | input | 1 | Physical (untranslated) mode |
| req_boot | input | 1 | Boot mode: fetches go to boot ROM |
| cfg_ctx_ptr | input | 32 | Context table pointer |
| cfg_ctx_num | input | 8 | Context number |
| cfg_rom_base | input | 36 | Boot ROM base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 36 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Access error, valid with mem_ack |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 36 | Physical address |
| rsp_size | output | 2 | Page size code (0 4 KB, 1 256 KB, 2 16 MB) |
| rsp_pte | output | 32 | Final entry, after any flag update |
| rsp_fault | output | 1 | Walk faulted |
| rsp_ftype | output | 3 | Fault type (1 or 4) |
| rsp_level | output | 2 | Level of the final or faulting read |

## Verification
The assertions check the timing rules on every cycle. These are: requests stay stable until acknowledged, no memory traffic while idle, the acceptance and response handshake, write-backs returning to the address just read with the referenced flag set, and the fault code set. Only the bench scenarios can show that the walk is correct. This covers the address composed at each level, the offset and size chosen by the level of the final entry, the fault level for each kind of bad entry or bus error, and the boot redirect. They also show which accesses trigger a write-back and what value reaches memory. For that, the bench preloads tables in its own memory model and compares responses and memory contents against hand-computed values.

// File: rtl/pt_walk_pkg.sv
// Shared types and constants for the page table walker.
// Assumes 32-bit table entries whose low two bits give the entry type.
package pt_walk_pkg;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_POINTER = 2'd1,
        ET_PAGE    = 2'd2,
        ET_RSVD    = 2'd3
    } entry_kind_e;

    typedef enum logic [1:0] {
        SZ_4K   = 2'd0,
        SZ_256K = 2'd1,
        SZ_16M  = 2'd2
    } page_size_e;

    typedef enum logic [1:0] {
        OUT_DESCEND = 2'd0,
        OUT_FINAL   = 2'd1,
        OUT_FAULT   = 2'd2
    } walk_outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WBACK = 2'd2,
        ST_RESP  = 2'd3
    } walk_state_e;

    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_TRANSL  = 3'd4;
    localparam int REF_BIT = 5;
    localparam int MOD_BIT = 6;

endpackage

// File: rtl/pt_walk_addr.sv
// Table address generator.
// Level 0 gives the context table slot. Levels 1..3 give the slot in the
// child table named by the pointer entry just read. Assumes PA_W > 32.
module pt_walk_addr #(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input  logic [1:0]       level,
    input  logic [31:12]     va_hi,
    input  logic [31:0]      ctx_ptr,
    input  logic [CTX_W-1:0] ctx_num,
    input  logic [31:2]      entry_hi,
    output logic [PA_W-1:0]  addr
);
    localparam int SHIFT = 4;
    localparam int SCALE = 2;

    logic [PA_W-1:0] base;
    logic [7:0]      index;

    // Select the base and the VA index field for the requested level.
    always_comb begin
        base  = PA_W'({entry_hi, 2'b00}) << SHIFT;
        index = '0;
        case (level)
            2'd0: begin
                base  = PA_W'(ctx_ptr) << SHIFT;
                index = 8'(ctx_num);
            end
            2'd1: index = va_hi[31:24];
            2'd2: index = {2'b00, va_hi[23:18]};
            default: index = {2'b00, va_hi[17:12]};
        endcase
    end

    // Word-scaled index added to the table base.
    always_comb addr = base + (PA_W'(index) << SCALE);

endmodule

// File: rtl/pt_entry_eval.sv
// Classifies a fetched entry at a given level and prepares the result of a
// final entry: physical address, size code, updated flags and the need for a
// write-back. Assumes level 0 is the context table.
module pt_entry_eval
    import pt_walk_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [1:0]      level,
    input  logic [31:0]     entry,
    input  logic [23:0]     va_lo,
    input  logic            is_write,
    input  logic            rd_err,
    output walk_outcome_e   outcome,
    output logic [2:0]      ftype,
    output logic [PA_W-1:0] paddr,
    output logic [1:0]      size,
    output logic [31:0]     upd_entry,
    output logic            need_wb
);
    localparam int PG_SH = 12;

    entry_kind_e     kind;
    logic [PA_W-1:0] frame;
    logic [23:0]     offset;

    always_comb kind = entry_kind_e'(entry[1:0]);

    // Decide whether the walk descends, ends on a page, or faults.
    always_comb begin
        outcome = OUT_FAULT;
        ftype   = FT_TRANSL;
        if (!rd_err) begin
            case (kind)
                ET_INVALID: ftype = FT_INVALID;
                ET_POINTER: if (level != 2'd3) outcome = OUT_DESCEND;
                ET_PAGE:    if (level != 2'd0) outcome = OUT_FINAL;
                default:    ftype = FT_TRANSL;
            endcase
        end
    end

    // Page offset and size code from the level where the page was found.
    always_comb begin
        case (level)
            2'd1:    begin offset = va_lo;                   size = SZ_16M;  end
            2'd2:    begin offset = {6'd0, va_lo[17:0]};     size = SZ_256K; end
            default: begin offset = {12'd0, va_lo[11:0]};    size = SZ_4K;   end
        endcase
    end

    // Frame base from the address field, then the translated address.
    always_comb begin
        frame = PA_W'(entry[31:8]) << PG_SH;
        paddr = frame + PA_W'(offset);
    end

    // Referenced / modified update and write-back decision.
    always_comb begin
        need_wb   = !entry[REF_BIT] || (is_write && !entry[MOD_BIT]);
        upd_entry = entry;
        upd_entry[REF_BIT] = 1'b1;
        if (is_write) upd_entry[MOD_BIT] = 1'b1;
    end

endmodule

// File: rtl/pt_walker.sv
// Page table walker top. Accepts one request at a time, walks the context
// table and up to three table levels, optionally writes back updated flags,
// then presents a one-cycle response. Assumes the memory port returns read
// data and error in the cycle mem_ack is high.
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int PA_W     = 36,
    parameter int CTX_W    = 8,
    parameter int ROM_OFSW = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_vaddr,
    input  logic             req_write,
    input  logic             req_fetch,
    input  logic             req_phys,
    input  logic             req_boot,
    input  logic [31:0]      cfg_ctx_ptr,
    input  logic [CTX_W-1:0] cfg_ctx_num,
    input  logic [PA_W-1:0]  cfg_rom_base,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_size,
    output logic [31:0]      rsp_pte,
    output logic             rsp_fault,
    output logic [2:0]       rsp_ftype,
    output logic [1:0]       rsp_level
);
    walk_state_e     state_q;
    logic [1:0]      lvl_q;
    logic [31:0]     va_q;
    logic            wr_q;
    logic [PA_W-1:0] ptr_q;
    logic [31:0]     wdata_q;

    logic [1:0]      gen_level;
    logic [31:0]     gen_va;
    logic [PA_W-1:0] gen_addr;
    logic [PA_W-1:0] phys_addr;

    walk_outcome_e   ev_out;
    logic [2:0]      ev_ftype;
    logic [PA_W-1:0] ev_paddr;
    logic [1:0]      ev_size;
    logic [31:0]     ev_upd;
    logic            ev_wb;

    // Level and address source for the next table address.
    always_comb begin
        gen_level = (state_q == ST_IDLE) ? 2'd0 : 2'(lvl_q + 2'd1);
        gen_va    = (state_q == ST_IDLE) ? req_vaddr : va_q;
    end

    pt_walk_addr #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
        .level    (gen_level),
        .va_hi    (gen_va[31:12]),
        .ctx_ptr  (cfg_ctx_ptr),
        .ctx_num  (cfg_ctx_num),
        .entry_hi (mem_rdata[31:2]),
        .addr     (gen_addr)
    );

    pt_entry_eval #(.PA_W(PA_W)) u_eval (
        .level     (lvl_q),
        .entry     (mem_rdata),
        .va_lo     (va_q[23:0]),
        .is_write  (wr_q),
        .rd_err    (mem_err),
        .outcome   (ev_out),
        .ftype     (ev_ftype),
        .paddr     (ev_paddr),
        .size      (ev_size),
        .upd_entry (ev_upd),
        .need_wb   (ev_wb)
    );

    // Untranslated address, with the boot ROM redirect for fetches.
    always_comb begin
        if (req_fetch && req_boot)
            phys_addr = cfg_rom_base | PA_W'(req_vaddr[ROM_OFSW-1:0]);
        else
            phys_addr = PA_W'(req_vaddr);
    end

    // Walk sequencer and response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lvl_q     <= '0;
            va_q      <= '0;
            wr_q      <= 1'b0;
            ptr_q     <= '0;
            wdata_q   <= '0;
            rsp_paddr <= '0;
            rsp_size  <= '0;
            rsp_pte   <= '0;
            rsp_fault <= 1'b0;
            rsp_ftype <= '0;
            rsp_level <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q <= req_vaddr;
                    wr_q <= req_write;
                    lvl_q <= 2'd0;
                    if (req_phys) begin
                        rsp_paddr <= phys_addr;
                        rsp_size  <= SZ_4K;
                        rsp_pte   <= '0;
                        rsp_fault <= 1'b0;
                        rsp_ftype <= '0;
                        rsp_level <= 2'd0;
                        state_q   <= ST_RESP;
                    end else begin
                        ptr_q   <= gen_addr;
                        state_q <= ST_READ;
                    end
                end
                ST_READ: if (mem_ack) begin
                    case (ev_out)
                        OUT_DESCEND: begin
                            ptr_q <= gen_addr;
                            lvl_q <= gen_level;
                        end
                        OUT_FINAL: begin
                            rsp_paddr <= ev_paddr;
                            rsp_size  <= ev_size;
                            rsp_pte   <= ev_upd;
                            rsp_fault <= 1'b0;
                            rsp_ftype <= '0;
                            rsp_level <= lvl_q;
                            wdata_q   <= ev_upd;
                            state_q   <= ev_wb ? ST_WBACK : ST_RESP;
                        end
                        default: begin
                            rsp_paddr <= '0;
                            rsp_size  <= SZ_4K;
                            rsp_pte   <= mem_rdata;
                            rsp_fault <= 1'b1;
                            rsp_ftype <= ev_ftype;
                            rsp_level <= lvl_q;
                            state_q   <= ST_RESP;
                        end
                    endcase
                end
                ST_WBACK: if (mem_ack) state_q <= ST_RESP;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Port views of the sequencer state.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        mem_req   = (state_q == ST_READ) || (state_q == ST_WBACK);
        mem_we    = (state_q == ST_WBACK);
        mem_addr  = ptr_q;
        mem_wdata = wdata_q;
        rsp_valid = (state_q == ST_RESP);
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12
    AST_WB_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> mem_addr == $past(mem_addr)); // R12
    AST_WB_REF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[REF_BIT]); // R8
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req); // R10
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready); // R11
    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_ftype == FT_INVALID || rsp_ftype == FT_TRANSL); // R5

endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
    localparam int PA_W = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic             req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0;
    logic             req_phys = 1'b0, req_boot = 1'b0;
    logic [31:0]      req_vaddr = '0, cfg_ctx_ptr = '0;
    logic [7:0]       cfg_ctx_num = '0;
    logic [PA_W-1:0]  cfg_rom_base = 36'hFF000_0000;
    logic             req_ready, mem_req, mem_we, mem_ack, mem_err, rsp_valid, rsp_fault;
    logic [PA_W-1:0]  mem_addr, rsp_paddr;
    logic [31:0]      mem_wdata, mem_rdata, rsp_pte;
    logic [1:0]       rsp_size, rsp_level;
    logic [2:0]       rsp_ftype;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_fetch(req_fetch),
        .req_phys(req_phys), .req_boot(req_boot), .cfg_ctx_ptr(cfg_ctx_ptr),
        .cfg_ctx_num(cfg_ctx_num), .cfg_rom_base(cfg_rom_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_size(rsp_size),
        .rsp_pte(rsp_pte), .rsp_fault(rsp_fault), .rsp_ftype(rsp_ftype), .rsp_level(rsp_level)
    );

    // Memory model: 8 KB of words, anything above is a bus error.
    logic [31:0] mem [0:2047];
    logic        ld_en = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [1:0]  lat = '0;
    logic [1:0]  wcnt;
    int          wr_cnt;
    logic        in_range;

    always_comb begin
        in_range  = (mem_addr[35:13] == '0);
        mem_ack   = mem_req && (wcnt == 2'd0);
        mem_rdata = in_range ? mem[mem_addr[12:2]] : 32'hDEAD_BEEF;
        mem_err   = mem_req && !in_range;
    end

    always @(posedge clk) begin
        if (!mem_req || mem_ack) wcnt <= lat;
        else                     wcnt <= wcnt - 2'd1;
        if (ld_en) mem[ld_addr[12:2]] <= ld_data;
        else if (mem_req && mem_we && mem_ack && in_range) begin
            mem[mem_addr[12:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end
    initial wr_cnt = 0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] ptr;
        logic [7:0]  ctx;
        logic [31:0] va;
        logic        wr, fe, ph, bt;
        logic [1:0]  lt;
        logic        flt;
        logic [2:0]  ft;
        logic [1:0]  lv;
        logic [35:0] pa;
        logic [1:0]  sz;
        logic [31:0] pte;
        logic        wb;
        logic [15:0] ea;
    } vec_t;

    // Expected results follow R1..R10 with the tables loaded below.
    localparam vec_t VECS [25] = '{
        '{32'h0, 8'd0, 32'h01ABCDEF, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,3'd0,2'd1, 36'h123ABCDEF, 2'd2, 32'h12300062, 1'b0, 16'h404}, // R4 16 MB
        '{32'h0, 8'd0, 32'h04000123, 1'b0,1'b0,1'b0,1'b0, 2'd2, 1'b0,3'd0,2'd1, 36'h456000123, 2'd2, 32'h45600022, 1'b1, 16'h410}, // R8 ref
        '{32'h0, 8'd0, 32'h0006ABCD, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b0,3'd0,2'd2, 36'h0ABC6ABCD, 2'd1, 32'h0ABC4022, 1'b0, 16'h804}, // R9 read
        '{32'h0, 8'd0, 32'h0006ABCD, 1'b1,1'b0,1'b0,1'b0, 2'd1, 1'b0,3'd0,2'd2, 36'h0ABC6ABCD, 2'd1, 32'h0ABC4062, 1'b1, 16'h804}, // R8 mod
        '{32'h0, 8'd0, 32'h0006ABCD, 1'b1,1'b0,1'b0,1'b0, 2'd0, 1'b0,3'd0,2'd2, 36'h0ABC6ABCD, 2'd1, 32'h0ABC4062, 1'b0, 16'h804}, // R9 write
        '{32'h0, 8'd0, 32'h00000ABC, 1'b1,1'b0,1'b0,1'b0, 2'd2, 1'b0,3'd0,2'd3, 36'h0FEDCBABC, 2'd0, 32'h0FEDCB62, 1'b1, 16'h900}, // R3 4 KB
        '{32'h0, 8'd0, 32'h00004FFF, 1'b0,1'b1,1'b0,1'b0, 2'd0, 1'b0,3'd0,2'd3, 36'h000777FFF, 2'd0, 32'h00077722, 1'b1, 16'h910}, // R3 idx4
        '{32'h0, 8'd0, 32'h00001000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd4,2'd3, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R6 ptr at L3
        '{32'h0, 8'd0, 32'h00002000, 1'b0,1'b0,1'b0,1'b0, 2'd1, 1'b1,3'd1,2'd3, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R5
        '{32'h0, 8'd0, 32'h00003000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd4,2'd3, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R6
        '{32'h0, 8'd0, 32'h02000000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd1,2'd1, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R5
        '{32'h0, 8'd0, 32'h03000000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd4,2'd1, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R6
        '{32'h0, 8'd0, 32'h00080000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd1,2'd2, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R5
        '{32'h0, 8'd0, 32'h05000000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd4,2'd2, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R6
        '{32'h0, 8'd0, 32'h050C0000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd4,2'd3, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R7
        '{32'h0, 8'd0, 32'h06000000, 1'b0,1'b0,1'b0,1'b0, 2'd2, 1'b1,3'd4,2'd2, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R7
        '{32'h0, 8'd1, 32'h00000000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd1,2'd0, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R5 ctx
        '{32'h0, 8'd2, 32'h00000000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd4,2'd0, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R6 ctx
        '{32'h0, 8'd3, 32'h00000000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd4,2'd0, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R6 page in ctx
        '{32'h0, 8'd4, 32'h00000000, 1'b0,1'b0,1'b0,1'b0, 2'd0, 1'b1,3'd4,2'd1, 36'h0, 2'd0, 32'h0, 1'b0, 16'h0}, // R7
        '{32'h0, 8'd0, 32'h89ABCDEF, 1'b0,1'b0,1'b1,1'b0, 2'd0, 1'b0,3'd0,2'd0, 36'h089ABCDEF, 2'd0, 32'h0, 1'b0, 16'h0}, // R10
        '{32'h0, 8'd0, 32'h89ABCDEF, 1'b0,1'b1,1'b1,1'b1, 2'd0, 1'b0,3'd0,2'd0, 36'hFF003CDEF, 2'd0, 32'h0, 1'b0, 16'h0}, // R10 boot
        '{32'h0, 8'd0, 32'h89ABCDEF, 1'b0,1'b0,1'b1,1'b1, 2'd0, 1'b0,3'd0,2'd0, 36'h089ABCDEF, 2'd0, 32'h0, 1'b0, 16'h0}, // R10 data
        '{32'h0, 8'd0, 32'h89ABCDEF, 1'b0,1'b1,1'b1,1'b0, 2'd0, 1'b0,3'd0,2'd0, 36'h089ABCDEF, 2'd0, 32'h0, 1'b0, 16'h0}, // R10 no boot
        '{32'h10, 8'd1, 32'h01ABCDEF, 1'b0,1'b0,1'b0,1'b0, 2'd1, 1'b0,3'd0,2'd1, 36'h123ABCDEF, 2'd2, 32'h12300062, 1'b0, 16'h404}  // R1 ptr
    };

    task automatic run_vec(input vec_t v, input int n);
        int w0;
        bit busy_ok = 1'b1;
        bit got = 1'b0;
        @(negedge clk);
        lat = v.lt; cfg_ctx_ptr = v.ptr; cfg_ctx_num = v.ctx; req_vaddr = v.va;
        req_write = v.wr; req_fetch = v.fe; req_phys = v.ph; req_boot = v.bt;
        req_valid = 1'b1;
        w0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < 100 && !got; c++) begin
            if (rsp_valid) got = 1'b1;
            else begin
                if (req_ready) busy_ok = 1'b0;
                @(negedge clk);
            end
        end
        chk(got, "R11", $sformatf("vec %0d response", n), 64'(got), 64'd1);
        if (!got) return;
        chk(busy_ok, "R11", $sformatf("vec %0d ready low while busy", n), 64'(busy_ok), 64'd1);
        chk(rsp_fault == v.flt && rsp_level == v.lv, v.flt ? "R5" : "R4",
            $sformatf("vec %0d fault/level", n), {rsp_fault, 2'b0, rsp_level}, {v.flt, 2'b0, v.lv});
        if (v.flt)
            chk(rsp_ftype == v.ft, v.ft == 3'd1 ? "R5" : "R6",
                $sformatf("vec %0d fault type", n), 64'(rsp_ftype), 64'(v.ft));
        else begin
            chk(rsp_paddr == v.pa, v.ph ? "R10" : "R4", $sformatf("vec %0d paddr", n), 64'(rsp_paddr), 64'(v.pa));
            chk(rsp_size == v.sz, "R4", $sformatf("vec %0d size", n), 64'(rsp_size), 64'(v.sz));
            chk(rsp_pte == v.pte, "R8", $sformatf("vec %0d pte", n), 64'(rsp_pte), 64'(v.pte));
            if (!v.ph)
                chk(mem[v.ea[12:2]] == v.pte, "R8", $sformatf("vec %0d memory entry", n),
                    64'(mem[v.ea[12:2]]), 64'(v.pte));
        end
        chk(wr_cnt - w0 == int'(v.wb), v.wb ? "R8" : "R9", $sformatf("vec %0d write count", n),
            64'(wr_cnt - w0), 64'(v.wb));
        @(negedge clk);
        chk(!rsp_valid && req_ready, "R11", $sformatf("vec %0d pulse ends", n), 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(req_ready == 1'b1, "R13", "ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R13", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        chk(mem_req == 1'b0, "R13", "mem_req in reset", 64'(mem_req), 64'd0);
        // R2 tables: context table at 0, level tables above it
        load(16'h000, 32'h00000041); load(16'h004, 32'h0);
        load(16'h008, 32'h3);        load(16'h00C, 32'h00001002);
        load(16'h010, 32'h00100001); load(16'h104, 32'h00000041);
        load(16'h400, 32'h81);       load(16'h404, 32'h12300062);
        load(16'h408, 32'h0);        load(16'h40C, 32'h3);
        load(16'h410, 32'h45600002); load(16'h414, 32'hA1);
        load(16'h418, 32'h00200001); load(16'h800, 32'h91);
        load(16'h804, 32'h0ABC4022); load(16'h808, 32'h0);
        load(16'h900, 32'h0FEDCB02); load(16'h904, 32'h1);
        load(16'h908, 32'h0);        load(16'h90C, 32'h3);
        load(16'h910, 32'h00077702); load(16'hA00, 32'h3);
        load(16'hA0C, 32'h00300001);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 25; i++) run_vec(VECS[i], i);
        // R13 reset in the middle of a walk
        lat = 2'd3; cfg_ctx_ptr = '0; cfg_ctx_num = '0; req_vaddr = 32'h00000ABC;
        req_write = 1'b0; req_fetch = 1'b0; req_phys = 1'b0; req_boot = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(mem_req == 1'b1, "R12", "request pending mid walk", 64'(mem_req), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(req_ready == 1'b1 && mem_req == 1'b0, "R13", "abandon after reset",
            {req_ready, mem_req}, 64'b10);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R13", "no stale response", 64'(rsp_valid), 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule